// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block sits between a clocked host and an external asynchronous static RAM of 16,384 one-bit words. The RAM has an active-low chip enable, an active-low write enable, a dedicated data-in line and a data-out line that floats unless the part is reading. The controller accepts one single-bit read or write request at a time over a valid/ready handshake. It turns each request into a strobe sequence whose phases each last a parameterised number of clock cycles, and it reports completion with a one-cycle pulse.

A write holds chip enable low for a lead phase and then drops write enable for the pulse phase. Both strobes rise on the same clock edge, and that edge ends the write. Address and data-in are set up at the start of the lead phase and are not changed until the next request is accepted. A read holds chip enable low with write enable high for the access phase, and samples data-out on the edge that closes that phase. A recovery phase, with both strobes high, follows every cycle before the next request can be taken.

Top module: `asram_cycle_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it is released, chip enable and write enable are both high (inactive), `req_ready` is 1, `done` is 0 and `rd_data` is 0.
- R2: Write enable is never low unless chip enable is also low in the same cycle.
- R3: A write accepted at a clock edge holds chip enable low and write enable high for SETUP_CYC cycles. It then holds both strobes low for PULSE_CYC cycles, and both strobes rise on the same edge. `ram_addr` and `ram_di` equal the request's address and bit for every cycle that chip enable is low.
- R4: A read accepted at a clock edge holds chip enable low and write enable high for ACC_CYC cycles, with `ram_addr` constant. `ram_do` is sampled on the edge that ends the last of these cycles, and never while either strobe state puts data-out in high impedance.
- R5: `done` is high for exactly the one cycle after the last strobe-low cycle of a request. For a read, `rd_data` takes the sampled bit in that same cycle and keeps it until the next read completes.
- R6: After `done`, both strobes stay high for RECOV_CYC cycles. `req_ready` is low from the cycle after acceptance until recovery ends. A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1.
- R7: With `req_valid` held high continuously, requests are accepted one after another, each as soon as the previous recovery ends, with no idle cycle in between.
- R8: A bit written to any address, including 0 and 16383, is returned by a later read of that address.
- R9: A write changes only the addressed location; a read of another address after it returns that address's last written value (0 if never written).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 14 | Word address of the request |
| req_wdata | input | 1 | Bit to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 1 | Bit returned by the most recent read |
| ram_addr | output | 14 | Address lines to the RAM |
| ram_ce_n | output | 1 | Chip enable to the RAM, active low |
| ram_we_n | output | 1 | Write enable to the RAM, active low |
| ram_di | output | 1 | Data-in line to the RAM |
| ram_do | input | 1 | Data-out line from the RAM |

## Verification
Isolated writes and reads separated by idle gaps show the phase lengths cleanly. Requests presented with `req_valid` held high show whether acceptance follows recovery with no lost or extra cycle. The RAM model drives the inverted bit until the access window has elapsed, so a read sampled one cycle early returns the wrong value. Writes at the two ends of the address range and at alternating-bit addresses, followed by read-back and overwrites, expose address or data corruption. A pseudo-random mix over a small set of addresses exposes writes that reach a neighbouring location.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_PULSE,
    ST_ACCESS,
    ST_RECOV
  } asram_st_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign last = (cnt == '0);

  // R6: every phase lasts at least one clock
  a_r6_phase_nonzero: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));

endmodule

// File: rtl/asram_pin_drive.sv
module asram_pin_drive #(
  parameter int ADDR_W    = 14,
  parameter int PULSE_CYC = 3,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              cap_di,
  input  logic              ce_on,
  input  logic              we_on,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_di
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr <= '0;
      ram_di   <= 1'b0;
      ram_ce_n <= 1'b1;
      ram_we_n <= 1'b1;
    end else begin
      if (cap) begin
        ram_addr <= cap_addr;
        ram_di   <= cap_di;
      end
      ram_ce_n <= ~ce_on;
      ram_we_n <= ~we_on;
    end
  end

  // checker: length of the current write-enable low pulse
  logic [CNT_W-1:0] we_lo_cnt;
  always_ff @(posedge clk) begin
    if (rst || ram_we_n) begin
      we_lo_cnt <= '0;
    end else if (we_lo_cnt != '1) begin
      we_lo_cnt <= we_lo_cnt + CNT_W'(1);
    end
  end

  // R2: write strobe only inside chip enable
  a_r2_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ram_ce_n);

  // R3: address and data frozen while the chip is enabled
  a_r3_pins_frozen: assert property (@(posedge clk) disable iff (rst)
    !ram_ce_n |=> (ram_ce_n || ($stable(ram_addr) && $stable(ram_di))));

  // R3: write pulse not shorter than PULSE_CYC
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> (int'(we_lo_cnt) >= PULSE_CYC));

  // R3: both strobes end the write together
  a_r3_joint_release: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> ram_ce_n);

endmodule

// File: rtl/asram_cycle_ctrl.sv
module asram_cycle_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int ACC_CYC   = 4,
  parameter int RECOV_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              done,
  output logic              rd_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_di,
  input  logic              ram_do
);

  localparam int MAX_CYC = max4(SETUP_CYC, PULSE_CYC, ACC_CYC, RECOV_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  asram_st_e        state, nxt;
  logic             t_load, t_last, cap, fin;
  logic [CNT_W-1:0] t_val;
  logic             ce_on, we_on;

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = '0;
    cap    = 1'b0;
    fin    = 1'b0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        cap    = 1'b1;
        t_load = 1'b1;
        nxt    = req_write ? ST_LEAD : ST_ACCESS;
        t_val  = req_write ? CNT_W'(SETUP_CYC) : CNT_W'(ACC_CYC);
      end
      ST_LEAD: if (t_last) begin
        nxt    = ST_PULSE;
        t_load = 1'b1;
        t_val  = CNT_W'(PULSE_CYC);
      end
      ST_PULSE, ST_ACCESS: if (t_last) begin
        nxt    = ST_RECOV;
        t_load = 1'b1;
        t_val  = CNT_W'(RECOV_CYC);
        fin    = 1'b1;
      end
      ST_RECOV: if (t_last) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign ce_on = (nxt == ST_LEAD) || (nxt == ST_PULSE) || (nxt == ST_ACCESS);
  assign we_on = (nxt == ST_PULSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      rd_data <= 1'b0;
    end else begin
      state <= nxt;
      done  <= fin;
      if (state == ST_ACCESS && t_last) rd_data <= ram_do;
    end
  end

  assign req_ready = (state == ST_IDLE);

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  asram_pin_drive #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (PULSE_CYC),
    .CNT_W     (CNT_W)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .cap      (cap),
    .cap_addr (req_addr),
    .cap_di   (req_wdata),
    .ce_on    (ce_on),
    .we_on    (we_on),
    .ram_addr (ram_addr),
    .ram_ce_n (ram_ce_n),
    .ram_we_n (ram_we_n),
    .ram_di   (ram_di)
  );

  // R5: completion pulse lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: not ready while recovering
  a_r6_busy_after_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_ready);

  // R4: the access phase drives a read strobe pattern
  a_r4_read_pins: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACCESS) |-> (!ram_ce_n && ram_we_n));

  // R6: acceptance leaves the idle state
  a_r6_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/asram_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module asram_cycle_ctrl_tb;

  localparam int AW = 14;
  localparam int SC = 2;
  localparam int PC = 3;
  localparam int AC = 4;
  localparam int RC = 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_ready, req_write, req_wdata;
  logic [AW-1:0] req_addr;
  logic          done, rd_data;
  logic [AW-1:0] ram_addr;
  logic          ram_ce_n, ram_we_n, ram_di, ram_do;
  logic          ram_do_r;

  assign ram_do = ram_do_r;
  always #5 clk = ~clk;

  asram_cycle_ctrl #(
    .ADDR_W(AW), .SETUP_CYC(SC), .PULSE_CYC(PC), .ACC_CYC(AC), .RECOV_CYC(RC)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
    .ram_we_n(ram_we_n), .ram_di(ram_di), .ram_do(ram_do)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 0;

  bit  ram_mem [int];
  bit  ref_mem [int];

  function automatic bit rd_mem(input bit is_ram, input int a);
    if (is_ram) return ram_mem.exists(a) ? ram_mem[a] : 1'b0;
    return ref_mem.exists(a) ? ref_mem[a] : 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // reference sequence state
  int k = -1;
  bit mw, md, pw, pd, acc_pend;
  int ma, pa;
  bit exp_rd;
  // RAM model state
  int ce_cnt, we_cnt, rd_cnt, prev_addr;
  bit prev_we_lo, prev_di, prev_rd;

  initial begin
    ram_do_r = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (rst) begin
        k = -1; acc_pend = 0; exp_rd = 0;
        ce_cnt = 0; we_cnt = 0; rd_cnt = 0; prev_we_lo = 0; prev_rd = 0;
        prev_addr = 0; prev_di = 0;
        chk("R1 reset ce_n", 32'(ram_ce_n), 32'd1);
        chk("R1 reset we_n", 32'(ram_we_n), 32'd1);
      end else begin
        bit e_ce, e_we, e_done, e_rdy;
        if (acc_pend) begin
          k = 0; mw = pw; ma = pa; md = pd;
          if (pw) ref_mem[pa] = pd;
        end else if (k >= 0) begin
          k++;
          if (k >= (mw ? SC + PC + RC : AC + RC)) k = -1;
        end
        e_ce = 1; e_we = 1; e_done = 0; e_rdy = (k < 0);
        if (k >= 0) begin
          if (mw) begin
            e_ce   = !(k < SC + PC);
            e_we   = !(k >= SC && k < SC + PC);
            e_done = (k == SC + PC);
          end else begin
            e_ce   = !(k < AC);
            e_done = (k == AC);
          end
        end
        if (e_done && !mw) exp_rd = rd_mem(0, ma);
        chk("R3/R4 chip enable", 32'(ram_ce_n), 32'(e_ce));
        chk("R2/R3 write enable", 32'(ram_we_n), 32'(e_we));
        chk("R6/R7 ready", 32'(req_ready), 32'(e_rdy));
        chk("R5 done", 32'(done), 32'(e_done));
        chk("R8/R9 read data", 32'(rd_data), 32'(exp_rd));
        if (!e_ce) chk("R3/R4 address", 32'(ram_addr), 32'(ma));
        if (!e_ce && mw) chk("R3 data-in", 32'(ram_di), 32'(md));
        acc_pend = req_valid && e_rdy;
        pw = req_write; pa = int'(req_addr); pd = req_wdata;

        // RAM model
        chk("R2 overlap", 32'(ram_we_n || !ram_ce_n), 32'd1);
        if (prev_we_lo && (ram_we_n || ram_ce_n)) begin
          chk("R3 pulse width", 32'(we_cnt >= PC), 32'd1);
          chk("R3 enable span", 32'(ce_cnt >= SC + PC), 32'd1);
          ram_mem[prev_addr] = prev_di;
          we_cnt = 0;
        end
        ce_cnt = ram_ce_n ? 0 : ce_cnt + 1;
        if (!ram_we_n) we_cnt++;
        if (!ram_ce_n && ram_we_n)
          rd_cnt = (prev_rd && int'(ram_addr) == prev_addr) ? rd_cnt + 1 : 1;
        else
          rd_cnt = 0;
        prev_rd    = !ram_ce_n && ram_we_n;
        prev_we_lo = !ram_we_n && !ram_ce_n;
        prev_addr  = int'(ram_addr);
        prev_di    = ram_di;
        ram_do_r   = (rd_cnt >= AC) ? rd_mem(1, int'(ram_addr)) : ~rd_mem(1, int'(ram_addr));
      end
    end
  end

  task automatic op(input bit w, input int a, input bit d);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = AW'(a);
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset ready", 32'(req_ready), 32'd1);
    chk("R1 reset done", 32'(done), 32'd0);
    chk("R1 reset rd_data", 32'(rd_data), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R3/R8: isolated writes at range ends and alternating-bit addresses
    op(1, 0, 1);        idle(3);
    op(1, 16383, 1);    idle(2);
    op(1, 'h1555, 0);   idle(1);
    op(1, 'h2AAA, 1);   idle(4);
    // R4/R8: isolated reads
    op(0, 0, 0);        idle(3);
    op(0, 16383, 0);    idle(2);
    // R7: back-to-back with valid held
    op(0, 'h2AAA, 0);
    op(0, 'h1555, 0);
    op(1, 0, 0);
    op(0, 0, 0);
    op(0, 1, 0);        // R9: never-written neighbour
    op(0, 16383, 0);
    idle(3);
    // R9: pseudo-random mix over a small address set
    lfsr = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op(lfsr[0], {lfsr[4], 9'd0, lfsr[3:1]} , lfsr[5]);
      if (lfsr[7]) idle(int'(lfsr[9:8]));
    end
    idle(10);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule